// File: doc/BRIEF.md
# Synchronous FIFO with Occupancy Thresholds

This block is a single-clock first-in first-out queue. The data width and the number of entries are parameters. A producer appends words at the tail with an enqueue strobe. A consumer always sees the oldest stored word on the output with no read latency, and removes it with a dequeue strobe.

Four flags report the occupancy. Two of them, full and empty, report the hard limits. The other two compare the stored count against configurable high and low thresholds, so that back-pressure logic upstream or downstream can react before a hard limit is reached.

A synchronous flush input throws away everything held, which suits pipelines that roll back speculative work. Requests that cannot be served are dropped without side effects: an enqueue while full, or a dequeue while empty.

Top module: `fifo_thr`

## Requirements
- R1: After the active-low asynchronous reset, the FIFO holds no entries: empty_o=1, aempty_o=1, full_o=0, and afull_o=0 whenever the high threshold is above zero.
- R2: While at least one entry is stored, pop_data_o shows the oldest entry combinationally, and it does not change in a cycle without an accepted dequeue or a flush.
- R3: Entries leave in the order they were accepted.
- R4: full_o is 1 exactly when the stored count equals DEPTH.
- R5: afull_o is 1 exactly when the stored count is greater than or equal to AFULL_LVL.
- R6: aempty_o is 1 exactly when the stored count is less than or equal to AEMPTY_LVL.
- R7: empty_o is 1 exactly when the stored count is zero.
- R8: An enqueue and a dequeue in the same cycle on a FIFO that is neither empty nor full leave the count unchanged. The head advances and the new word joins the tail.
- R9: flush_i takes priority over enqueue and dequeue in the same cycle, and the FIFO is empty in the following cycle.
- R10: An enqueue while full_o=1 is ignored, even when a dequeue is accepted in the same cycle: the count and the contents are unchanged apart from that dequeue.
- R11: A dequeue while empty_o=1 is ignored. An enqueue in the same cycle is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Enqueue strobe |
| push_data_i | input | DATA_W | Word appended at the tail |
| pop_i | input | 1 | Dequeue strobe |
| flush_i | input | 1 | Discard all entries |
| pop_data_o | output | DATA_W | Oldest stored word (show-ahead) |
| full_o | output | 1 | Count equals DEPTH |
| empty_o | output | 1 | Count is zero |
| afull_o | output | 1 | Count at or above AFULL_LVL |
| aempty_o | output | 1 | Count at or below AEMPTY_LVL |

## Verification
Each accepted strobe takes effect at the next rising edge. All four flags and the head word are decoded from registered state, so every result is due one clock after the stimulus. The bench drives inputs on the falling edge and advances its queue model at the rising edge. It then compares the flags and, when the model is not empty, the head word on the next falling edge. Because this sampling point is half a period after the only edge at which state can change, a same-cycle write, such as the first word into an empty FIFO, is visible exactly one cycle after it was offered.

// File: rtl/fifo_thr_pkg.sv
package fifo_thr_pkg;

  // Qualified operations for one cycle.
  typedef struct packed {
    logic wr;
    logic rd;
    logic clr;
  } fifo_op_t;

  function automatic int unsigned cnt_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/fifo_thr_ctrl.sv
module fifo_thr_ctrl
  import fifo_thr_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = ptr_bits(DEPTH),
  localparam int unsigned CNT_W = cnt_bits(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output fifo_op_t         op_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             is_full, is_empty;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  assign is_full  = (cnt_q == DEPTH_C);
  assign is_empty = (cnt_q == '0);

  // Flush wins; requests that cannot be served are dropped.
  always_comb begin
    op_o.clr = flush_i;
    op_o.wr  = push_i & ~is_full  & ~flush_i;
    op_o.rd  = pop_i  & ~is_empty & ~flush_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (op_o.clr) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (op_o.wr) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (op_o.rd) rd_ptr_q <= ptr_inc(rd_ptr_q);
      unique case ({op_o.wr, op_o.rd})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/fifo_thr_store.sv
module fifo_thr_store
  import fifo_thr_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = ptr_bits(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[e] <= '0;
      end else if (wr_i && (wr_ptr_i == PTR_W'(e))) begin
        mem_q[e] <= wdata_i;
      end
    end
  end

  // Show-ahead: head is read without a register stage.
  assign rdata_o = mem_q[rd_ptr_i];

endmodule

// File: rtl/fifo_thr_flags.sv
module fifo_thr_flags
  import fifo_thr_pkg::*;
#(
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned AFULL_LVL  = DEPTH,
  parameter int unsigned AEMPTY_LVL = 1,
  localparam int unsigned CNT_W = cnt_bits(DEPTH)
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic             full_o,
  output logic             empty_o,
  output logic             afull_o,
  output logic             aempty_o
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HI_C    = CNT_W'(AFULL_LVL);
  localparam logic [CNT_W-1:0] LO_C    = CNT_W'(AEMPTY_LVL);

  assign full_o   = (cnt_i == DEPTH_C);
  assign empty_o  = (cnt_i == '0);
  assign afull_o  = (cnt_i >= HI_C);
  assign aempty_o = (cnt_i <= LO_C);

endmodule

// File: rtl/fifo_thr.sv
module fifo_thr
  import fifo_thr_pkg::*;
#(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned AFULL_LVL  = DEPTH,
  parameter int unsigned AEMPTY_LVL = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              afull_o,
  output logic              aempty_o
);

  localparam int unsigned PTR_W = ptr_bits(DEPTH);
  localparam int unsigned CNT_W = cnt_bits(DEPTH);

  fifo_op_t         op;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] occ_cnt;

  fifo_thr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .flush_i  (flush_i),
    .op_o     (op),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr),
    .cnt_o    (occ_cnt)
  );

  fifo_thr_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (op.wr),
    .wr_ptr_i (wr_ptr),
    .wdata_i  (push_data_i),
    .rd_ptr_i (rd_ptr),
    .rdata_o  (pop_data_o)
  );

  fifo_thr_flags #(
    .DEPTH(DEPTH), .AFULL_LVL(AFULL_LVL), .AEMPTY_LVL(AEMPTY_LVL)
  ) u_flags (
    .cnt_i    (occ_cnt),
    .full_o   (full_o),
    .empty_o  (empty_o),
    .afull_o  (afull_o),
    .aempty_o (aempty_o)
  );

endmodule

// File: rtl/fifo_thr_chk.sv
module fifo_thr_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic              flush_i,
  input logic [DATA_W-1:0] pop_data_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              afull_o,
  input logic              aempty_o,
  input logic [CNT_W-1:0]  occ_cnt
);

  AST_HEAD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !pop_i && !flush_i) |=> $stable(pop_data_o)); // R2

  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R4

  AST_FULL_IMPLIES_AFULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> afull_o); // R5

  AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> aempty_o); // R6

  AST_PAIRED_OPS_HOLD_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !full_o && push_i && pop_i && !flush_i) |=> (occ_cnt == $past(occ_cnt))); // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (full_o && $stable(pop_data_o))); // R10

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !flush_i) |=> empty_o); // R11

endmodule

bind fifo_thr fifo_thr_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .flush_i    (flush_i),
  .pop_data_o (pop_data_o),
  .full_o     (full_o),
  .empty_o    (empty_o),
  .afull_o    (afull_o),
  .aempty_o   (aempty_o),
  .occ_cnt    (occ_cnt)
);

// File: tb/tb_fifo_thr.sv
module tb_fifo_thr;

  localparam int DW    = 64;
  localparam int DEPTH = 4;
  localparam int HI    = 3;
  localparam int LO    = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push = 1'b0, pop = 1'b0, flush = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          full, empty, afull, aempty;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;
  logic [DW-1:0] mq[$];

  always #5 clk = ~clk;

  fifo_thr #(.DATA_W(DW), .DEPTH(DEPTH), .AFULL_LVL(HI), .AEMPTY_LVL(LO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(din),
    .pop_i(pop), .flush_i(flush), .pop_data_o(dout),
    .full_o(full), .empty_o(empty), .afull_o(afull), .aempty_o(aempty)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // Compare all outputs against the queue model.
  task automatic compare(input string tag);
    int sz = mq.size();
    chk(empty  == (sz == 0),     {"R7 ", tag}, DW'(empty),  DW'(sz == 0));
    chk(full   == (sz == DEPTH), {"R4 ", tag}, DW'(full),   DW'(sz == DEPTH));
    chk(afull  == (sz >= HI),    {"R5 ", tag}, DW'(afull),  DW'(sz >= HI));
    chk(aempty == (sz <= LO),    {"R6 ", tag}, DW'(aempty), DW'(sz <= LO));
    if (sz != 0) chk(dout == mq[0], {"R2 R3 ", tag}, dout, mq[0]);
  endtask

  // Called at a falling edge: drive, let the rising edge pass, update model, check.
  task automatic step(input bit pu, input bit po, input bit fl, input logic [DW-1:0] d, input string tag);
    bit was_full, was_empty;
    push = pu; pop = po; flush = fl; din = d;
    @(posedge clk);
    was_full  = (mq.size() == DEPTH);
    was_empty = (mq.size() == 0);
    if (fl) mq.delete();
    else begin
      if (po && !was_empty) void'(mq.pop_front());
      if (pu && !was_full)  mq.push_back(d);
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  always @(posedge clk) cyc++;

  initial begin
    logic [DW-1:0] pre;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(empty == 1'b1 && aempty == 1'b1 && full == 1'b0 && afull == 1'b0, "R1 reset flags",
        DW'({empty, aempty, full, afull}), DW'(4'b1100));
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R3 R4 R5: fill to the top
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, DW'(64'hA000 + i), "fill");
    // R10: push while full is ignored
    step(1, 0, 0, 64'hDEAD, "R10 push full");
    chk(dout == 64'hA000, "R10 head kept", dout, 64'hA000);
    // R10: push with pop while full, only the pop takes effect
    step(1, 1, 0, 64'hBEEF, "R10 push+pop full");
    chk(full == 1'b0, "R10 count dropped", DW'(full), 0);
    // R3: drain in order
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, '0, "drain");
    // R11: pop while empty ignored
    step(0, 1, 0, '0, "R11 pop empty");
    chk(empty == 1'b1, "R11 still empty", DW'(empty), 1);
    // R11: push with pop while empty accepts the push
    step(1, 1, 0, 64'h5151, "R11 push+pop empty");
    chk(dout == 64'h5151 && !empty, "R11 push kept", dout, 64'h5151);
    step(1, 0, 0, 64'h5252, "prep");
    // R8: paired ops keep count
    for (int i = 0; i < 6; i++) begin
      pre = DW'({full, afull, aempty});
      step(1, 1, 0, DW'(64'hC000 + i), "R8 paired");
      chk(DW'({full, afull, aempty}) == pre, "R8 flags unchanged", DW'({full, afull, aempty}), pre);
    end
    // R9: flush beats push and pop
    step(1, 1, 1, 64'h7777, "R9 flush");
    chk(empty == 1'b1, "R9 empty after flush", DW'(empty), 1);
    step(1, 0, 0, 64'h8888, "R9 refill");
    chk(dout == 64'h8888, "R9 head after flush", dout, 64'h8888);
    // Mixed traffic against the model
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 2) != 0, $urandom_range(0, 2) != 0, $urandom_range(0, 30) == 0,
           {$urandom, $urandom}, "mixed");
    step(0, 0, 0, '0, "idle");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule